// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control register file of an audio codec front end. A host reaches it over a simple 32-bit word bus with valid and write strobes. The window is 64 bytes wide and holds sixteen word registers. Most of them are plain 32-bit storage.

Three word registers have special behaviour. Word 0 acts as a pointer. Its low five bits pick one of thirty-two byte-wide codec registers. Word 1 is a data port into the codec register that the pointer picks. Word 4 is a control word, and writing a one to its lowest bit triggers a software reset.

Some codec registers follow their own access rules. One can be written but never read back. Two are fixed and ignore writes. One always keeps a fixed version code in its bits while software may toggle a single flag. Host software sets the pointer first and then moves bytes through the data port. The hardware reset and the software reset both load the same identification values.

Top module: `codec_ctl_regs`

## Requirements
- R1: The word index is byte address bits 5:2, and address bits 1:0 are ignored. Every word other than 0, 1, 2 and 4 stores all 32 written bits and reads them back unchanged.
- R2: Word 0 stores all 32 written bits and reads them back. Its bits 4:0 select the codec register that word 1 reaches.
- R3: A write to word 1 stores bus data bits 7:0 into the selected codec register. A read of word 1 returns that register zero-extended to 32 bits.
- R4: Codec register 3 always reads as zero, whatever was written to it.
- R5: Codec registers 11 and 25 ignore writes. Register 11 always reads 0x00 and register 25 always reads 0xA0.
- R6: A write to codec register 12 stores (data AND 0x40) OR 0x8A, so a read returns 0x8A or 0xCA.
- R7: Word 2 ignores writes and always reads zero.
- R8: A write to word 4 with bit 0 set first returns every register to its reset value. Word 4 then holds the written data AND 0x7F.
- R9: A write to word 4 with bit 0 clear stores the written data AND 0x7F and leaves every other register unchanged.
- R10: While rst_n is low at a rising clock edge, every word clears to zero and bus_rdata clears to zero. The codec registers also clear, except register 12, which loads 0x8A, and register 25, which loads 0xA0.
- R11: bus_rdata is loaded at the clock edge that samples a read (valid high, write low). It keeps its value in every other cycle, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | High for a write, low for a read |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block at its default sizes: a 6-bit byte address, 32-bit data and 32 codec registers. At these sizes every word and every codec register can be swept in full. Each codec index is written and read back with several data patterns, so every access rule and the pointer decode meet each value class. The software reset is triggered both with and without its trigger bit, and the hardware reset is applied in the middle of the run. Each is followed by a full sweep against a model that the bench derives from the requirements.

// File: rtl/codec_regs_pkg.sv
// Shared constants for the codec control register file.
// Assumes a 64-byte window of sixteen words and byte-wide codec registers.
package codec_regs_pkg;
    localparam int N_DIR       = 16;
    localparam int N_IND       = 32;
    localparam int IND_W       = 8;
    localparam int DIR_IDX_W   = $clog2(N_DIR);
    localparam int IND_IDX_W   = $clog2(N_IND);

    // Word indices with special behaviour
    localparam int W_PTR       = 0;
    localparam int W_PORT      = 1;
    localparam int W_STAT      = 2;
    localparam int W_CTRL      = 4;
    localparam int CTRL_KEEP_W = 7;

    // Codec register indices with special behaviour
    localparam int C_WONLY     = 3;
    localparam int C_FIX_A     = 11;
    localparam int C_VER       = 12;
    localparam int C_FIX_B     = 25;
    localparam logic [7:0] VER_CODE = 8'h8A;
    localparam logic [7:0] ID_CODE  = 8'hA0;
    localparam logic [7:0] VER_FLAG = 8'h40;

    typedef enum logic [1:0] {K_PLAIN, K_FIXED, K_VERSION} ckind_e;

    // Access class of a codec register
    function automatic ckind_e ckind(input int idx);
        if (idx == C_FIX_A || idx == C_FIX_B) return K_FIXED;
        if (idx == C_VER)                     return K_VERSION;
        return K_PLAIN;
    endfunction

    // Reset contents of a codec register
    function automatic logic [7:0] creset(input int idx);
        if (idx == C_VER)   return VER_CODE;
        if (idx == C_FIX_B) return ID_CODE;
        return 8'h00;
    endfunction
endpackage

// File: rtl/codec_ind_bank.sv
// Bank of byte-wide codec registers reached through the pointer and port.
// Each index takes its access rule from the package. The clear input is the
// software reset and has the same effect as rst_n.
module codec_ind_bank
    import codec_regs_pkg::*;
#(
    parameter int NREG = N_IND,
    parameter int RW   = IND_W,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] rdata
);
    logic [RW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (ckind(g) == K_FIXED) begin : g_fixed
            assign regs[g] = RW'(creset(g));
        end else begin : g_store
            // Holds one codec register under its write rule
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    regs[g] <= RW'(creset(g));
                else if (we && idx == IW'(g))
                    regs[g] <= (ckind(g) == K_VERSION)
                             ? ((wdata & RW'(VER_FLAG)) | RW'(VER_CODE))
                             : wdata;
            end
        end
    end

    // Read view: the write-only register never shows its contents
    always_comb begin
        rdata = (idx == IW'(C_WONLY)) ? '0 : regs[idx];
    end

    AST_VER_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[C_VER] & RW'(VER_CODE)) == RW'(VER_CODE)); // R6
    AST_CLR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (regs[C_VER] == RW'(VER_CODE))); // R8
endmodule

// File: rtl/codec_dir_bank.sv
// Sixteen 32-bit words. The port word and the status word have no storage.
// The control word masks what is written to it, and setting its bit 0
// asserts clr for the other banks.
module codec_dir_bank
    import codec_regs_pkg::*;
#(
    parameter int NREG  = N_DIR,
    parameter int DW    = 32,
    parameter int PTR_W = IND_IDX_W,
    localparam int IW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [PTR_W-1:0] ptr,
    output logic             clr
);
    localparam logic [DW-1:0] CTRL_MASK = DW'((64'd1 << CTRL_KEEP_W) - 64'd1);

    logic [DW-1:0] regs [NREG];

    // Software reset request: a write to the control word with bit 0 set
    assign clr = we && (idx == IW'(W_CTRL)) && wdata[0];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        if (g == W_PORT || g == W_STAT) begin : g_none
            assign regs[g] = '0;
        end else if (g == W_CTRL) begin : g_ctrl
            // Control word, which keeps its masked value even when it triggers the reset
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (we && idx == IW'(g))
                    regs[g] <= wdata & CTRL_MASK;
            end
        end else begin : g_plain
            // Plain storage word, cleared by either reset
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    regs[g] <= '0;
                else if (we && idx == IW'(g))
                    regs[g] <= wdata;
            end
        end
    end

    assign rdata = regs[idx];
    assign ptr   = regs[W_PTR][PTR_W-1:0];

    AST_CTRL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[W_CTRL] & ~CTRL_MASK) == '0); // R9
    AST_SOFT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (regs[W_PTR] == '0)); // R8
endmodule

// File: rtl/codec_ctl_regs.sv
// Top of the codec control register file. Decodes the word index, sends
// port accesses to the codec bank and everything else to the word bank,
// and registers the read data. Assumes one access per cycle.
module codec_ctl_regs
    import codec_regs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int WI_W = ADDR_W - 2;

    logic [WI_W-1:0]      word;
    logic [1:0]           addr_unused;
    logic                 wr, rd, to_port;
    logic [DATA_W-1:0]    dir_rd;
    logic [IND_W-1:0]     ind_rd;
    logic [IND_IDX_W-1:0] ptr;
    logic                 clr;

    // Address split and access decode
    assign word        = bus_addr[ADDR_W-1:2];
    assign addr_unused = bus_addr[1:0];
    assign wr          = bus_valid && bus_write;
    assign rd          = bus_valid && !bus_write;
    assign to_port     = (word == WI_W'(W_PORT));

    codec_dir_bank #(.NREG(1 << WI_W), .DW(DATA_W), .PTR_W(IND_IDX_W)) u_dir (
        .clk(clk), .rst_n(rst_n), .we(wr && !to_port), .idx(word),
        .wdata(bus_wdata), .rdata(dir_rd), .ptr(ptr), .clr(clr)
    );

    codec_ind_bank #(.NREG(N_IND), .RW(IND_W)) u_ind (
        .clk(clk), .rst_n(rst_n), .clr(clr), .we(wr && to_port), .idx(ptr),
        .wdata(bus_wdata[IND_W-1:0]), .rdata(ind_rd)
    );

    // Registered read data, which holds between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd)
            bus_rdata <= to_port ? DATA_W'(ind_rd) : dir_rd;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata)); // R11
    AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && word == WI_W'(W_STAT)) |=> (bus_rdata == '0)); // R7
endmodule

// File: tb/sim_codec_ctl_regs.sv
// Self-checking bench that sweeps every word and codec register against a model.
module sim_codec_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] wm [16];
    logic [7:0]  cm [32];

    always #5 clk = ~clk;

    codec_ctl_regs u0 (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) wm[i] = '0;
        for (int i = 0; i < 32; i++) cm[i] = '0;
        cm[12] = 8'h8A;
        cm[25] = 8'hA0;
    endtask

    function automatic logic [31:0] exp_word(input int w);
        int c;
        c = int'(wm[0][4:0]);
        if (w == 1) return (c == 3) ? 32'h0 : {24'h0, cm[c]};
        if (w == 2) return 32'h0;
        return wm[w];
    endfunction

    task automatic model_write(input int w, input logic [31:0] d);
        int c;
        c = int'(wm[0][4:0]);
        if (w == 1) begin
            if (c == 12) cm[c] = (d[7:0] & 8'h40) | 8'h8A;
            else if (c != 11 && c != 25) cm[c] = d[7:0];
        end else if (w == 4) begin
            if (d[0]) model_reset();
            wm[4] = d & 32'h7F;
        end else if (w != 2) begin
            wm[w] = d;
        end
    endtask

    task automatic bwrite(input int w, input logic [31:0] d, input logic [1:0] lo);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = {w[3:0], lo}; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        model_write(w, d);
    endtask

    task automatic bread(input int w, input logic [1:0] lo, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = {w[3:0], lo};
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    function automatic string ctag(input int c);
        if (c == 3) return "R4";
        if (c == 11 || c == 25) return "R5";
        if (c == 12) return "R6";
        return "R3";
    endfunction

    function automatic string wtag(input int w);
        if (w == 0) return "R2";
        if (w == 2) return "R7";
        if (w == 4) return "R9";
        return "R1";
    endfunction

    task automatic sweep_words(input string tag);
        logic [31:0] d;
        for (int w = 0; w < 16; w++) begin
            bread(w, 2'(w), d);
            chk((tag == "") ? wtag(w) : tag, d, exp_word(w));
        end
    endtask

    task automatic sweep_codec(input string tag);
        logic [31:0] d;
        for (int c = 0; c < 32; c++) begin
            bwrite(0, 32'(c), 2'b00);
            bread(1, 2'b00, d);
            chk((tag == "") ? ctag(c) : tag, d, exp_word(1));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d, held;
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h1234_5678;
        model_reset();
        repeat (3) @(negedge clk);
        chk("R10", bus_rdata, 32'h0);
        rst_n = 1'b1;
        sweep_words("R10");
        sweep_codec("R10");

        // R3 R4 R5 R6: write every codec register with several patterns
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 32; c++) begin
                bwrite(0, 32'(c) | (pats[p] & 32'hFFFF_FFE0), 2'(c));
                bwrite(1, pats[p] ^ (32'(c) * 32'h0101_0125), 2'(p));
            end
            sweep_codec("");
        end

        // R1 R2 R7: every word written with two patterns, low address bits varied
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 16; w++)
                if (w != 1 && w != 4) bwrite(w, pats[p+2] + 32'(w) * 32'h0001_0003, 2'(w + p));
            sweep_words("");
        end

        // R9: control word without the trigger bit
        bwrite(4, 32'hFFFF_FFFE, 2'b00);
        sweep_words("R9");
        sweep_codec("R9");

        // R8: control word with the trigger bit
        bwrite(0, 32'h0000_0007, 2'b00);
        bwrite(1, 32'h0000_0033, 2'b00);
        bwrite(4, 32'hFFFF_FF83, 2'b00);
        sweep_words("R8");
        sweep_codec("R8");

        // R11: read data holds across writes and idle cycles
        bwrite(6, 32'hCAFE_0006, 2'b00);
        bread(6, 2'b00, held);
        chk("R11", held, 32'hCAFE_0006);
        bwrite(6, 32'h0BAD_0BAD, 2'b00);
        chk("R11", bus_rdata, held);
        repeat (3) @(negedge clk);
        chk("R11", bus_rdata, held);

        // R10: hardware reset during operation
        bwrite(9, 32'h5555_AAAA, 2'b00);
        bwrite(0, 32'd12, 2'b00);
        bwrite(1, 32'h40, 2'b00);
        bread(9, 2'b00, d);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", bus_rdata, 32'h0);
        rst_n = 1'b1;
        model_reset();
        sweep_words("R10");
        sweep_codec("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule